// File: doc/BRIEF.md
# Midrange Memory Chip-Select Decoder

This block decodes one user-placed memory window into four select outputs, one per quarter of the window. Software supplies the window base and a size code; the base is forced down to the window's alignment, so a misaligned base still yields a well-formed window. Addresses that belong to the upper boot region, the low region, or a peripheral window mapped into memory are never decoded here. A peripheral window placed in I/O space does not remove anything from the decode.

Pins 1 to 3 can take other roles. In whole-window mode, pin 0 asserts across the entire window and pins 1 to 3 become general-purpose pins. Enabling a DRAM bank turns pins 1 and 2 into column strobes, and enabling the upper bank turns pin 3 into the second row strobe. A quarter whose pin has been given another role asserts no select, but the access still reports a window hit, so its wait states are still applied. The block publishes a function code for each pin. The select levels are registered on the cycle that presents the address phase. Generating the strobe waveforms is left to other logic.

Top module: `mcs_decoder`

## Requirements
- R1: The window size is 8 KiB shifted left by `blk_size_i` for codes 0 to 6; codes of 7 and above are treated as 512 KiB. The window starts at `blk_base_i` rounded down to a multiple of the size. `hit_o` is 1 only for addresses inside that window.
- R2: Outside whole-window mode, a hit in quarter n (the address offset divided by a quarter of the size) raises only `sel_o[n]`, and only if pin n has function code 0. `quarter_o` reports n on a hit and 0 otherwise.
- R3: Any address at or above `upper_base_i` gives no hit and no select.
- R4: Any address below `lower_end_i` gives no hit and no select.
- R5: With `periph_in_mem_i`=1, the 1 KiB range starting at `periph_base_i` rounded down to 1 KiB gives no hit. With `periph_in_mem_i`=0, that range has no effect on the decode.
- R6: In whole-window mode (`whole_range_i`=1), every hit raises `sel_o[0]` only, whatever the quarter.
- R7: Each pin has a 3-bit code in `pin_fn_o[3n+2:3n]`, where 0 means select, 1 general-purpose, 2 upper column strobe, 3 lower column strobe, and 4 second row strobe. Pin 0 is always 0. Pins 1 and 2 take codes 2 and 3 when either bank is enabled; otherwise they take 1 in whole-window mode and 0 outside it. Pin 3 takes code 4 when the upper bank is enabled; otherwise it takes 1 in whole-window mode and 0 outside it.
- R8: A hit in a quarter whose pin code is not 0 still sets `hit_o` but raises no select.
- R9: `sel_o`, `hit_o`, `quarter_o` and `wide_o` take the decode of the address presented with `addr_valid_i`=1 at one rising edge, starting just after that edge. After an edge with `addr_valid_i`=0 they are all 0.
- R10: `wide_o` equals `wide_bus_i` on a hit and is 0 otherwise.
- R11: While `rst_ni` is low, `sel_o`, `hit_o`, `quarter_o` and `wide_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 20 | Byte address of the access |
| addr_valid_i | input | 1 | Address phase present this cycle |
| blk_base_i | input | 20 | Window base (aligned down internally) |
| blk_size_i | input | 3 | Window size code |
| whole_range_i | input | 1 | Pin 0 covers the whole window |
| dram_lo_en_i | input | 1 | Lower DRAM bank enabled |
| dram_hi_en_i | input | 1 | Upper DRAM bank enabled |
| wide_bus_i | input | 1 | Window uses the 16-bit data path |
| upper_base_i | input | 20 | Lowest address of the upper region |
| lower_end_i | input | 20 | First address above the low region |
| periph_base_i | input | 20 | Peripheral window base |
| periph_in_mem_i | input | 1 | Peripheral window lies in memory space |
| sel_o | output | 4 | Registered select levels, active high |
| hit_o | output | 1 | Registered window hit (wait states apply) |
| quarter_o | output | 2 | Quarter of the last hit |
| wide_o | output | 1 | Data width of the last hit |
| pin_fn_o | output | 12 | Per-pin function codes, 3 bits per pin |

## Verification
The remapping of a pin and the decode of its quarter apply in the same cycle. When a quarter's pin has become a strobe, the hit must still be reported with no select raised. The bench drives every combination of the two bank enables and whole-window mode for every size code, and probes one address in each quarter. Each result is compared against a model that derives the pin codes and the expected select from the requirements. Exclusion and window membership also apply in the same cycle. These are judged by placing the window over the low region, the upper region and a memory-mapped peripheral range, and by expecting a hit to appear only where none of those ranges claims the address.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int NUM_PINS = 4;
  localparam int FN_W     = 3;

  typedef enum logic [FN_W-1:0] {
    FN_CS     = 3'd0,
    FN_GPIO   = 3'd1,
    FN_CAS_HI = 3'd2,
    FN_CAS_LO = 3'd3,
    FN_RAS_HI = 3'd4
  } pin_fn_e;
endpackage

// File: rtl/mcs_range_dec.sv
module mcs_range_dec #(
  parameter int ADDR_W     = 20,
  parameter int MIN_BLK_W  = 13,
  parameter int SIZE_CODES = 7,
  localparam int SZ_W      = $clog2(SIZE_CODES)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [SZ_W-1:0]   size_i,
  output logic              in_blk_o,
  output logic [1:0]        quarter_o
);
  logic [SZ_W-1:0]   eff_code;
  logic [ADDR_W-1:0] blk_mask;
  logic [ADDR_W-1:0] offs_q;

  always_comb begin
    eff_code  = (int'(size_i) >= SIZE_CODES) ? SZ_W'(SIZE_CODES - 1) : size_i;
    blk_mask  = {ADDR_W{1'b1}} << (MIN_BLK_W + int'(eff_code));
    in_blk_o  = ((addr_i ^ base_i) & blk_mask) == '0;
    offs_q    = addr_i >> (MIN_BLK_W - 2 + int'(eff_code));
    quarter_o = offs_q[1:0];
  end
endmodule

// File: rtl/mcs_excl.sv
module mcs_excl #(
  parameter int ADDR_W     = 20,
  parameter int PCS_SPAN_W = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] upper_base_i,
  input  logic [ADDR_W-1:0] lower_end_i,
  input  logic [ADDR_W-1:0] periph_base_i,
  input  logic              periph_in_mem_i,
  output logic              excl_o
);
  logic in_upper, in_lower, in_periph;

  always_comb begin
    in_upper  = addr_i >= upper_base_i;
    in_lower  = addr_i < lower_end_i;
    in_periph = periph_in_mem_i &&
                ((addr_i >> PCS_SPAN_W) == (periph_base_i >> PCS_SPAN_W));
    excl_o    = in_upper | in_lower | in_periph;
  end
endmodule

// File: rtl/mcs_pin_map.sv
module mcs_pin_map
  import mcs_pkg::*;
(
  input  logic                     whole_range_i,
  input  logic                     dram_lo_en_i,
  input  logic                     dram_hi_en_i,
  output logic [NUM_PINS*FN_W-1:0] pin_fn_o,
  output logic [NUM_PINS-1:0]      cs_ok_o
);
  logic any_dram;
  assign any_dram = dram_lo_en_i | dram_hi_en_i;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    pin_fn_e fn;
    if (g == 0) begin : g_base
      assign fn = FN_CS;
    end else if (g < 3) begin : g_cas
      assign fn = any_dram      ? ((g == 1) ? FN_CAS_HI : FN_CAS_LO) :
                  whole_range_i ? FN_GPIO : FN_CS;
    end else begin : g_ras
      assign fn = dram_hi_en_i  ? FN_RAS_HI :
                  whole_range_i ? FN_GPIO : FN_CS;
    end
    assign pin_fn_o[g*FN_W +: FN_W] = fn;
    assign cs_ok_o[g]               = (fn == FN_CS);
  end
endmodule

// File: rtl/mcs_decoder.sv
module mcs_decoder
  import mcs_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int MIN_BLK_W  = 13,
  parameter int SIZE_CODES = 7,
  parameter int PCS_SPAN_W = 10,
  localparam int SZ_W      = $clog2(SIZE_CODES)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     addr_valid_i,
  input  logic [ADDR_W-1:0]        blk_base_i,
  input  logic [SZ_W-1:0]          blk_size_i,
  input  logic                     whole_range_i,
  input  logic                     dram_lo_en_i,
  input  logic                     dram_hi_en_i,
  input  logic                     wide_bus_i,
  input  logic [ADDR_W-1:0]        upper_base_i,
  input  logic [ADDR_W-1:0]        lower_end_i,
  input  logic [ADDR_W-1:0]        periph_base_i,
  input  logic                     periph_in_mem_i,
  output logic [NUM_PINS-1:0]      sel_o,
  output logic                     hit_o,
  output logic [1:0]               quarter_o,
  output logic                     wide_o,
  output logic [NUM_PINS*FN_W-1:0] pin_fn_o
);
  logic                in_blk, excl, hit_d;
  logic [1:0]          quarter;
  logic [NUM_PINS-1:0] cs_ok, sel_d;

  mcs_range_dec #(.ADDR_W(ADDR_W), .MIN_BLK_W(MIN_BLK_W), .SIZE_CODES(SIZE_CODES)) u_range (
    .addr_i   (addr_i),
    .base_i   (blk_base_i),
    .size_i   (blk_size_i),
    .in_blk_o (in_blk),
    .quarter_o(quarter)
  );

  mcs_excl #(.ADDR_W(ADDR_W), .PCS_SPAN_W(PCS_SPAN_W)) u_excl (
    .addr_i         (addr_i),
    .upper_base_i   (upper_base_i),
    .lower_end_i    (lower_end_i),
    .periph_base_i  (periph_base_i),
    .periph_in_mem_i(periph_in_mem_i),
    .excl_o         (excl)
  );

  mcs_pin_map u_pins (
    .whole_range_i(whole_range_i),
    .dram_lo_en_i (dram_lo_en_i),
    .dram_hi_en_i (dram_hi_en_i),
    .pin_fn_o     (pin_fn_o),
    .cs_ok_o      (cs_ok)
  );

  always_comb begin
    hit_d = addr_valid_i & in_blk & ~excl;
    sel_d = '0;
    if (hit_d) begin
      if (whole_range_i) sel_d[0] = 1'b1;
      else               sel_d = (NUM_PINS'(1) << quarter) & cs_ok;
    end
  end

  // Registered on the address phase edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o     <= '0;
      hit_o     <= 1'b0;
      quarter_o <= '0;
      wide_o    <= 1'b0;
    end else begin
      sel_o     <= sel_d;
      hit_o     <= hit_d;
      quarter_o <= hit_d ? quarter : 2'd0;
      wide_o    <= hit_d & wide_bus_i;
    end
  end
endmodule

// File: rtl/mcs_decoder_chk.sv
module mcs_decoder_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              addr_valid_i,
  input logic              whole_range_i,
  input logic              dram_lo_en_i,
  input logic              dram_hi_en_i,
  input logic [ADDR_W-1:0] upper_base_i,
  input logic [ADDR_W-1:0] lower_end_i,
  input logic [3:0]        sel_o,
  input logic              hit_o,
  input logic              wide_o,
  input logic [11:0]       pin_fn_o
);
  p_sel_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  p_sel_needs_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != 4'b0) |-> hit_o);
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(addr_valid_i) |-> (sel_o == 4'b0 && !hit_o && !wide_o));
  p_whole_sel0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(whole_range_i) && hit_o) |-> (sel_o == 4'b0001));
  p_upper_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ($past(addr_i) < $past(upper_base_i)));
  p_lower_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ($past(addr_i) >= $past(lower_end_i)));
  p_ras_pin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_hi_en_i |-> (pin_fn_o[11:9] == 3'd4 && pin_fn_o[2:0] == 3'd0));
  p_cas_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(dram_lo_en_i) || $past(dram_hi_en_i)) |-> (sel_o[2:1] == 2'b00));
endmodule

bind mcs_decoder mcs_decoder_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .addr_valid_i (addr_valid_i),
  .whole_range_i(whole_range_i),
  .dram_lo_en_i (dram_lo_en_i),
  .dram_hi_en_i (dram_hi_en_i),
  .upper_base_i (upper_base_i),
  .lower_end_i  (lower_end_i),
  .sel_o        (sel_o),
  .hit_o        (hit_o),
  .wide_o       (wide_o),
  .pin_fn_o     (pin_fn_o)
);

// File: tb/mcs_decoder_tb.sv
module mcs_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic        valid = 1'b0;
  logic [19:0] base = '0;
  logic [2:0]  size = '0;
  logic        whole = 1'b0, dlo = 1'b0, dhi = 1'b0, wide = 1'b0;
  logic [19:0] ubase = 20'hF0000, lend = 20'h08000, pbase = 20'h20000;
  logic        pmem = 1'b1;
  logic [3:0]  sel;
  logic        hit, wide_q;
  logic [1:0]  quart;
  logic [11:0] pfn;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  mcs_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .addr_valid_i(valid),
    .blk_base_i(base), .blk_size_i(size), .whole_range_i(whole),
    .dram_lo_en_i(dlo), .dram_hi_en_i(dhi), .wide_bus_i(wide),
    .upper_base_i(ubase), .lower_end_i(lend), .periph_base_i(pbase),
    .periph_in_mem_i(pmem), .sel_o(sel), .hit_o(hit), .quarter_o(quart),
    .wide_o(wide_q), .pin_fn_o(pfn)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_fn(input int pin);
    if (pin == 0) return 0;
    if (pin < 3) return (dlo || dhi) ? (pin == 1 ? 2 : 3) : (whole ? 1 : 0);
    return dhi ? 4 : (whole ? 1 : 0);
  endfunction

  task automatic check_pins();
    for (int p = 0; p < 4; p++) chk("R7 pin code", int'(pfn[p*3 +: 3]), exp_fn(p));
  endtask

  task automatic probe(input int a);
    int blk, bal, pal, q, e_sel;
    bit inb, excl, e_hit;
    blk   = 8192 << ((size > 6) ? 6 : int'(size));
    bal   = int'(base) - (int'(base) % blk);
    pal   = int'(pbase) - (int'(pbase) % 1024);
    inb   = (a >= bal) && (a < bal + blk);
    excl  = (a >= int'(ubase)) || (a < int'(lend)) || (pmem && a >= pal && a < pal + 1024);
    e_hit = inb && !excl;
    q     = e_hit ? (a - bal) / (blk / 4) : 0;
    e_sel = !e_hit ? 0 : whole ? 1 : (exp_fn(q) == 0 ? (1 << q) : 0);
    @(negedge clk);
    addr  = 20'(a);
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    chk("R1/R3/R4/R5 hit", int'(hit), int'(e_hit));
    chk("R2/R6/R8 sel", int'(sel), e_sel);
    chk("R2 quarter", int'(quart), q);
    chk("R10 wide", int'(wide_q), int'(e_hit && wide));
    @(negedge clk);
    chk("R9 idle", int'({sel, hit, wide_q}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset", int'({sel, hit, quart, wide_q}), 0);
    rst_n = 1'b1;

    // Full sweep: sizes x bank enables x whole mode x quarters
    for (int c = 0; c < 7; c++) begin
      size = 3'(c);
      base = 20'h81234;
      for (int m = 0; m < 8; m++) begin
        int blk, bal;
        dlo   = m[0];
        dhi   = m[1];
        whole = m[2];
        wide  = m[0] ^ m[2];
        blk   = 8192 << c;
        bal   = int'(base) - (int'(base) % blk);
        @(negedge clk);
        check_pins();
        for (int qq = 0; qq < 4; qq++) probe(bal + qq * (blk / 4) + 16);
        probe(bal - 1);
        probe(bal + blk - 1);
      end
    end

    dlo = 1'b0; dhi = 1'b0; whole = 1'b0; wide = 1'b1;
    // R1: code 7 clamps to 512 KiB
    size = 3'd7; base = 20'h80000;
    probe(32'h80010); probe(32'hC0010); probe(32'h7FFF0);
    // R5: peripheral window in memory vs I/O
    size = 3'd3; base = 20'h20000;
    pmem = 1'b1; probe(32'h20100); probe(32'h20400);
    pmem = 1'b0; probe(32'h20100);
    // R3: window under the upper region
    base = 20'hF0000; probe(32'hF4000); probe(32'hFFFFF);
    // R4: window over the low region
    base = 20'h00000; probe(32'h04000); probe(32'h07FFF); probe(32'h08000); probe(32'h0C000);
    // R8: strobe quarters still report a hit
    base = 20'h40000; dlo = 1'b1;
    probe(32'h44000); probe(32'h48000); probe(32'h4C000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule